// File: doc/BRIEF.md
# Multi-Region CRC-16 Frame Checker

This block folds a bit-serial stream into one CRC-16 while a framing parser marks which stretches of the stream are protected. The parser pulses a region-open strobe and supplies a signed length limit. It feeds bits with a valid qualifier and pulses a region-close strobe. It can repeat this for several regions per frame. When the frame is complete, it pulses a check strobe together with the 16-bit value carried in the frame. The block then reports whether the running CRC matches that value.

Each region may carry a positive length limit. Surplus bits past that limit are dropped. If the region closes early, it is topped up with zero bits. The zero fill is done one bit per clock, and a ready output stalls the stream while it runs. A limit of zero or less means every qualified bit inside the region is used as is. The register starts at all ones for every frame and is not cleared between regions, so the regions chain in the order they were opened.

Top module: `crc_region_checker`

## Requirements
- R1: The CRC uses generator 0x8005 and takes bits MSB-first. For each bit, the feedback is the incoming bit XOR crc[15]. The register shifts left by one and XORs in 0x8005 when the feedback is 1. The register holds 0xFFFF at reset and again after every accepted check.
- R2: A bit with bit_valid_i high counts only while a region is open. Bits that arrive while no region is open, and bits with bit_valid_i low, leave the CRC unchanged.
- R3: If a region's limit is positive, only the first limit bits that arrive in that region enter the CRC. Any later bits in the region are dropped.
- R4: If a region's limit is positive and it closes after fewer bits than the limit, (limit − seen) zero bits enter the CRC. They are fed one per clock, starting in the cycle after the close strobe, and ready_o is low for exactly that many cycles.
- R5: If a region's limit is zero or negative, every qualified bit up to the close strobe is used. ready_o stays high.
- R6: All regions of a frame feed one running CRC, in the order they were opened. The register is not re-initialised between regions.
- R7: A check strobe accepted in cycle k produces done_o high in cycle k+1 for one cycle. In that same cycle, crc_o holds the computed CRC, and pass_o=1/fail_o=0 on a match with crc_exp_i (pass_o=0/fail_o=1 otherwise). pass_o and fail_o hold until the next check.
- R8: A check strobe is ignored while a region is open or zero fill is in progress. done_o stays low and the CRC is unaffected.
- R9: At most 8 regions may be opened per frame. An open strobe beyond that count is ignored and sets ovf_o. ovf_o stays set until the next accepted check clears it, along with the region count.
- R10: After reset: done_o, pass_o, fail_o and ovf_o are 0, crc_o is 0x0000, and ready_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_i | input | 1 | Serial stream bit |
| bit_valid_i | input | 1 | bit_i is valid this cycle |
| ready_o | output | 1 | Low while zero fill stalls the stream |
| reg_start_i | input | 1 | Open a region |
| reg_max_i | input | MAX_W | Signed length limit of the region being opened |
| reg_end_i | input | 1 | Close the open region |
| check_i | input | 1 | Finish the frame and compare |
| crc_exp_i | input | 16 | CRC value taken from the frame |
| done_o | output | 1 | One-cycle result strobe |
| pass_o | output | 1 | Last check matched |
| fail_o | output | 1 | Last check mismatched |
| crc_o | output | 16 | CRC computed by the last check |
| ovf_o | output | 1 | Region limit exceeded in this frame |

## Verification
The embedded properties assume the parser never overlaps regions. An open strobe arriving while a region is open or zero fill is running is treated as ignored, not as nesting. The properties also assume that a bit presented during zero fill is held back by the source. The stimulus keeps to these limits. It opens a region only after the previous one has closed and ready_o has returned high, and it drives stray bits only while no region is open.

// File: rtl/crc_region_pkg.sv
package crc_region_pkg;
  localparam int          CRC_W    = 16;
  localparam logic [15:0] CRC_POLY = 16'h8005;
  localparam logic [15:0] CRC_INIT = 16'hFFFF;

  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic b);
    return {c[14:0], 1'b0} ^ (((b ^ c[15]) == 1'b1) ? CRC_POLY : 16'h0000);
  endfunction
endpackage

// File: rtl/crc_lfsr_unit.sv
module crc_lfsr_unit
  import crc_region_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             en_i,
  input  logic             bit_i,
  output logic [CRC_W-1:0] crc_o
);
  logic [CRC_W-1:0] crc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      crc_q <= CRC_INIT;
    else if (clear_i) crc_q <= CRC_INIT;
    else if (en_i)    crc_q <= crc_step(crc_q, bit_i);
  end

  assign crc_o = crc_q;

  // R1
  init_after_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (crc_o == CRC_INIT));
  // R2
  hold_when_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && !en_i) |=> $stable(crc_o));
endmodule

// File: rtl/region_ctrl.sv
module region_ctrl #(
  parameter int NREG  = 8,
  parameter int MAX_W = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic signed [MAX_W-1:0] max_i,
  input  logic                    end_i,
  input  logic                    bit_i,
  input  logic                    valid_i,
  input  logic                    clear_i,
  output logic                    feed_en_o,
  output logic                    feed_bit_o,
  output logic                    ready_o,
  output logic                    idle_o,
  output logic                    ovf_o
);
  localparam int CNT_W = $clog2(NREG + 1);
  localparam logic [CNT_W-1:0] NREG_C = CNT_W'(NREG);

  logic                    active_q, pad_q, ovf_q;
  logic signed [MAX_W-1:0] max_q;
  logic [MAX_W-1:0]        seen_q, pad_left_q;
  logic [CNT_W-1:0]        cnt_q;

  logic             idle, pos_max, take_bit, start_ok, start_ovf, close, need_pad;
  logic [MAX_W-1:0] max_u, seen_nxt;

  assign idle      = !active_q && !pad_q;
  assign max_u     = $unsigned(max_q);
  assign pos_max   = (max_q > 0);
  assign take_bit  = active_q && valid_i && (!pos_max || (seen_q < max_u));
  assign start_ok  = start_i && idle && !clear_i && (cnt_q < NREG_C);
  assign start_ovf = start_i && idle && !clear_i && (cnt_q == NREG_C);
  assign close     = active_q && end_i;
  assign seen_nxt  = seen_q + MAX_W'(take_bit && pos_max);
  assign need_pad  = pos_max && (seen_nxt < max_u);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q   <= 1'b0;
      pad_q      <= 1'b0;
      ovf_q      <= 1'b0;
      max_q      <= '0;
      seen_q     <= '0;
      pad_left_q <= '0;
      cnt_q      <= '0;
    end else begin
      if (clear_i) begin
        cnt_q <= '0;
        ovf_q <= 1'b0;
      end
      if (start_ovf) ovf_q <= 1'b1;
      if (start_ok) begin
        active_q <= 1'b1;
        max_q    <= max_i;
        seen_q   <= '0;
        cnt_q    <= cnt_q + CNT_W'(1);
      end else if (active_q) begin
        seen_q <= seen_nxt;
        if (close) begin
          active_q <= 1'b0;
          if (need_pad) begin
            pad_q      <= 1'b1;
            pad_left_q <= max_u - seen_nxt;
          end
        end
      end else if (pad_q) begin
        pad_left_q <= pad_left_q - MAX_W'(1);
        if (pad_left_q == MAX_W'(1)) pad_q <= 1'b0;
      end
    end
  end

  assign feed_en_o  = take_bit || pad_q;
  assign feed_bit_o = pad_q ? 1'b0 : bit_i;
  assign ready_o    = !pad_q;
  assign idle_o     = idle;
  assign ovf_o      = ovf_q;

  // R9
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= NREG_C);
  // R9
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_ovf |=> (ovf_o && !active_q && $stable(cnt_q)));
  // R3
  clip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && pos_max && (seen_q == max_u)) |-> !feed_en_o);
  // R4
  pad_exclusive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pad_q |-> (!active_q && pad_left_q != '0));
endmodule

// File: rtl/crc_region_checker.sv
module crc_region_checker
  import crc_region_pkg::*;
#(
  parameter int NREG  = 8,
  parameter int MAX_W = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    bit_i,
  input  logic                    bit_valid_i,
  output logic                    ready_o,
  input  logic                    reg_start_i,
  input  logic signed [MAX_W-1:0] reg_max_i,
  input  logic                    reg_end_i,
  input  logic                    check_i,
  input  logic [15:0]             crc_exp_i,
  output logic                    done_o,
  output logic                    pass_o,
  output logic                    fail_o,
  output logic [15:0]             crc_o,
  output logic                    ovf_o
);
  logic feed_en, feed_bit, idle, chk_ok;
  logic [CRC_W-1:0] crc_run;
  logic done_q, pass_q, fail_q;
  logic [CRC_W-1:0] res_q;

  assign chk_ok = check_i && idle;

  region_ctrl #(.NREG(NREG), .MAX_W(MAX_W)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (reg_start_i),
    .max_i      (reg_max_i),
    .end_i      (reg_end_i),
    .bit_i      (bit_i),
    .valid_i    (bit_valid_i),
    .clear_i    (chk_ok),
    .feed_en_o  (feed_en),
    .feed_bit_o (feed_bit),
    .ready_o    (ready_o),
    .idle_o     (idle),
    .ovf_o      (ovf_o)
  );

  crc_lfsr_unit u_crc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (chk_ok),
    .en_i    (feed_en),
    .bit_i   (feed_bit),
    .crc_o   (crc_run)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q <= 1'b0;
      pass_q <= 1'b0;
      fail_q <= 1'b0;
      res_q  <= '0;
    end else begin
      done_q <= chk_ok;
      if (chk_ok) begin
        res_q  <= crc_run;
        pass_q <= (crc_run == crc_exp_i);
        fail_q <= (crc_run != crc_exp_i);
      end
    end
  end

  assign done_o = done_q;
  assign pass_o = pass_q;
  assign fail_o = fail_q;
  assign crc_o  = res_q;

  // R7
  verdict_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (pass_o != fail_o));
  // R7
  done_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(check_i));
  // R8
  check_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (check_i && (!ready_o || !idle)) |=> !done_o);
endmodule

// File: tb/crc_region_checker_bench.sv
module crc_region_checker_bench;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_W = 16;

  logic clk = 0, rst_ni = 0;
  logic bit_s = 0, valid_s = 0, start_s = 0, end_s = 0, check_s = 0;
  logic signed [MAX_W-1:0] max_s = '0;
  logic [15:0] exp_s = '0;
  logic ready, done, pass, fail, ovf;
  logic [15:0] crc;

  int vectors = 0, fails = 0;
  logic [15:0] model = 16'hFFFF;

  always #(CLK_PERIOD/2) clk = ~clk;

  crc_region_checker u_crc_region_checker (
    .clk_i(clk), .rst_ni(rst_ni), .bit_i(bit_s), .bit_valid_i(valid_s),
    .ready_o(ready), .reg_start_i(start_s), .reg_max_i(max_s),
    .reg_end_i(end_s), .check_i(check_s), .crc_exp_i(exp_s),
    .done_o(done), .pass_o(pass), .fail_o(fail), .crc_o(crc), .ovf_o(ovf)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] expv);
    vectors++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  // R1: polynomial division by x^16+x^15+x^2+1, MSB first
  function automatic logic [15:0] mstep(logic [15:0] c, logic b);
    logic [16:0] w;
    w = {c, 1'b0};
    if (w[16] ^ b) w = w ^ 17'h18005;
    return w[15:0];
  endfunction

  task automatic stray(int k);
    for (int i = 0; i < k; i++) begin
      bit_s = 1'($urandom); valid_s = 1; @(negedge clk);
    end
    valid_s = 0;
  endtask

  task automatic run_region(int n, int mx, bit gaps, string req);
    int pad, cnt;
    logic b;
    start_s = 1; max_s = MAX_W'(mx); @(negedge clk);
    start_s = 0;
    for (int i = 0; i < n; i++) begin
      if (gaps && ($urandom % 3 == 0)) begin
        bit_s = 1'($urandom); valid_s = 0; @(negedge clk);
      end
      b = 1'($urandom); bit_s = b; valid_s = 1;
      if (mx <= 0 || i < mx) model = mstep(model, b);
      @(negedge clk);
    end
    valid_s = 0; end_s = 1; @(negedge clk);
    end_s = 0;
    pad = (mx > 0 && n < mx) ? mx - n : 0;
    for (int j = 0; j < pad; j++) model = mstep(model, 1'b0);
    cnt = 0;
    while (!ready && cnt < 1000) begin cnt++; @(negedge clk); end
    chk({req, " R4 fill cycles"}, 32'(cnt), 32'(pad));
  endtask

  task automatic do_check(bit flip, string req);
    exp_s = model ^ {15'h0, flip};
    check_s = 1; @(negedge clk);
    check_s = 0;
    chk({req, " R7 done"}, {31'h0, done}, 1);
    chk({req, " R7 crc"}, {16'h0, crc}, {16'h0, model});
    chk({req, " R7 pass"}, {31'h0, pass}, {31'h0, !flip});
    chk({req, " R7 fail"}, {31'h0, fail}, {31'h0, flip});
    model = 16'hFFFF;
    @(negedge clk);
    chk("R7 done one cycle", {31'h0, done}, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 done", {31'h0, done}, 0);
    chk("R10 pass", {31'h0, pass}, 0);
    chk("R10 fail", {31'h0, fail}, 0);
    chk("R10 crc", {16'h0, crc}, 0);
    chk("R10 ovf", {31'h0, ovf}, 0);
    chk("R10 ready", {31'h0, ready}, 1);
    rst_ni = 1; @(negedge clk);

    // single-region sweep over limit and length, R2 stray bits between frames
    for (int mx = -2; mx <= 12; mx++)
      for (int n = 0; n <= 12; n++) begin
        string r;
        r = (mx <= 0) ? "R5" : (n > mx) ? "R3" : (n < mx) ? "R4" : "R1";
        stray(2); // R2
        run_region(n, mx, (n % 2) == 1, r);
        stray(3); // R2
        do_check(((n + mx) % 5) == 0, r);
      end

    // R6 chained regions
    for (int f = 0; f < 6; f++) begin
      for (int k = 0; k < 3; k++) begin
        run_region(int'($urandom % 20), int'($urandom % 24) - 6, 1'b1, "R6");
        stray(1);
      end
      do_check(f % 2 == 1, "R6");
    end

    // R8 check while open, then while filling
    start_s = 1; max_s = 16'sd10; @(negedge clk);
    start_s = 0;
    for (int i = 0; i < 4; i++) begin
      bit_s = 1'(i); valid_s = 1; model = mstep(model, 1'(i)); @(negedge clk);
    end
    valid_s = 0; check_s = 1; @(negedge clk);
    check_s = 0;
    chk("R8 check during region", {31'h0, done}, 0);
    end_s = 1; @(negedge clk);
    end_s = 0;
    for (int j = 0; j < 6; j++) model = mstep(model, 1'b0);
    check_s = 1; @(negedge clk);
    check_s = 0;
    chk("R8 check during fill", {31'h0, done}, 0);
    while (!ready) @(negedge clk);
    do_check(1'b0, "R8");

    // R9 region limit
    for (int k = 0; k < 8; k++) run_region(k % 3, 0, 1'b0, "R9");
    chk("R9 ovf before", {31'h0, ovf}, 0);
    start_s = 1; max_s = 16'sd0; @(negedge clk);
    start_s = 0;
    chk("R9 ovf set", {31'h0, ovf}, 1);
    stray(5);
    end_s = 1; @(negedge clk);
    end_s = 0;
    chk("R9 ready", {31'h0, ready}, 1);
    do_check(1'b0, "R9");
    chk("R9 ovf cleared", {31'h0, ovf}, 0);
    run_region(7, 0, 1'b0, "R9 after clear");
    do_check(1'b0, "R9 after clear");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule